// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test access port in the style of IEEE 1149.1. A tester drives a test clock, a mode-select line and a serial data input, and reads a serial data output. A sixteen-state controller steps on each rising edge of the test clock according to the mode-select level. It routes the serial stream either into a six-bit instruction register or into the data register that the active instruction selects.

Four data paths can be selected. The first is a one-bit bypass stage. The second is a 32-bit identification word. The third is a 16-bit user signature, which can be read, and written at the end of a data scan when the write instruction is active. The fourth is a 12-bit status word, loaded from a parallel input vector at capture time. When the instruction path is captured, it loads the identification opcode. A tester that walks a chain without loading any instruction therefore reads the identification word. The identification word has bit 0 at 1, which tells it apart from a bypass stage.

The serial output and its enable change on the falling edge of the test clock. Between scans the serial output stays in its high-impedance condition, signalled by a low enable.

Top module: `scan_tap_port`

## Requirements
- R1: While `por_n` is low, the port holds the reset state. The controller is in Test-Logic-Reset, the identification instruction (6'h01) is active, `tdo_oe` and `tdo` are 0, and the user signature equals `USIG_INIT`.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. It stays there while `tms` is high and moves to Run-Test/Idle on the first low `tms`. Every cycle in Test-Logic-Reset makes the identification instruction active again.
- R3: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge. `tdo_oe` is 1 exactly while the controller is in Shift-DR or Shift-IR. Outside those states `tdo` keeps its last value.
- R4: Capture-IR loads 6'h01, so the first six bits shifted out of the instruction path are 1,0,0,0,0,0. At Update-IR the shifted-in value becomes the active instruction. Bits enter at bit 5 and leave from bit 0.
- R5: Opcode 6'h01 selects the 32-bit identification word `ID_VALUE`. It is shifted out least significant bit first, with bit 0 always 1.
- R6: Opcode 6'h3F selects the bypass stage. So does any opcode other than 6'h01 to 6'h04. The bypass stage captures 0, and a bit on `tdi` reaches `tdo` one shift later.
- R7: Opcode 6'h02 reads the 16-bit user signature, least significant bit first. Opcode 6'h03 reads it as well, and at Update-DR writes the last 16 bits shifted in, with the earliest of them as bit 0.
- R8: Opcode 6'h04 loads `status_in` at Capture-DR and shifts its 12 bits out least significant bit first.
- R9: An Update-DR under any instruction other than 6'h03 leaves the user signature unchanged.
- R10: Pause-DR holds the data shift path. `tdo_oe` is 0 there. A scan resumed through Exit2-DR continues from the bit where it stopped.
- R11: Run-Test/Idle with `tms` low changes nothing, and `tdo_oe` stays 0 whatever `tdi` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| status_in | input | STAT_W | Parallel vector loaded by the status path at capture |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; high only during shift states |

## Verification
A wrong controller state shows at the ports within half a test clock. The output enable rises or falls on the wrong falling edge, or a scan returns a word shifted by one position. A wrong active instruction or a corrupted shift path only appears when the next data scan shifts out. The bench therefore follows every state change with a complete scan of a known word, and compares the serial output and its enable on every falling edge against its own queue-based model of the port.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 6;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SELECT,
        ST_DR_CAPTURE,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPDATE,
        ST_IR_SELECT,
        ST_IR_CAPTURE,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPDATE
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_USIG,
        SEL_STATUS
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_IDCODE  = IR_W'(1);
    localparam logic [IR_W-1:0] OP_USIG_RD = IR_W'(2);
    localparam logic [IR_W-1:0] OP_USIG_WR = IR_W'(3);
    localparam logic [IR_W-1:0] OP_STATUS  = IR_W'(4);
    localparam logic [IR_W-1:0] OP_BYPASS  = '1;

    function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
        dr_sel_e sel;
        case (op)
            OP_IDCODE:  sel = SEL_IDCODE;
            OP_USIG_RD: sel = SEL_USIG;
            OP_USIG_WR: sel = SEL_USIG;
            OP_STATUS:  sel = SEL_STATUS;
            OP_BYPASS:  sel = SEL_BYPASS;
            default:    sel = SEL_BYPASS;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.state)
            ST_RESET:      fsm_d.state = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       fsm_d.state = tms ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT:  fsm_d.state = tms ? ST_IR_SELECT : ST_DR_CAPTURE;
            ST_DR_CAPTURE: fsm_d.state = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   fsm_d.state = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   fsm_d.state = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   fsm_d.state = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   fsm_d.state = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  fsm_d.state = tms ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT:  fsm_d.state = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: fsm_d.state = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   fsm_d.state = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   fsm_d.state = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   fsm_d.state = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   fsm_d.state = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  fsm_d.state = tms ? ST_DR_SELECT : ST_IDLE;
            default:       fsm_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            fsm_q <= '{state: ST_RESET};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.state;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter logic [IR_W-1:0] CAPTURE_OP = OP_IDCODE
) (
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_lsb,
    output logic [IR_W-1:0] ir_active
);

    typedef struct packed {
        logic [IR_W-1:0] shift;
        logic [IR_W-1:0] active;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state)
            ST_RESET:      ir_d.active = CAPTURE_OP;
            ST_IR_CAPTURE: ir_d.shift  = CAPTURE_OP;
            ST_IR_SHIFT:   ir_d.shift  = {tdi, ir_q.shift[IR_W-1:1]};
            ST_IR_UPDATE:  ir_d.active = ir_q.shift;
            default:       ir_d = ir_q;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_q <= '{shift: '0, active: CAPTURE_OP};
        end else begin
            ir_q <= ir_d;
        end
    end

    assign ir_lsb    = ir_q.shift[0];
    assign ir_active = ir_q.active;

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              ID_W      = 32,
    parameter logic [ID_W-1:0] ID_VALUE  = 32'h1B3C_5A71,
    parameter int              USIG_W    = 16,
    parameter logic [USIG_W-1:0] USIG_INIT = 16'hA5C3,
    parameter int              STAT_W    = 12
) (
    input  logic              tck,
    input  logic              por_n,
    input  tap_state_e        state,
    input  logic              tdi,
    input  dr_sel_e           sel,
    input  logic              usig_wr_en,
    input  logic [STAT_W-1:0] status_in,
    output logic              dr_lsb,
    output logic [USIG_W-1:0] usig
);

    localparam int WIDE_A = (ID_W > USIG_W) ? ID_W : USIG_W;
    localparam int DR_W   = (WIDE_A > STAT_W) ? WIDE_A : STAT_W;
    localparam int IDX_W  = (DR_W > 1) ? $clog2(DR_W) : 1;

    localparam logic [IDX_W-1:0] TOP_ID   = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] TOP_USIG = IDX_W'(USIG_W - 1);
    localparam logic [IDX_W-1:0] TOP_STAT = IDX_W'(STAT_W - 1);
    localparam logic [IDX_W-1:0] TOP_BYP  = '0;

    typedef struct packed {
        logic [DR_W-1:0]   shift;
        logic [USIG_W-1:0] usig;
    } dr_t;

    dr_t              dr_d, dr_q;
    logic [IDX_W-1:0] top_idx;
    logic [DR_W-1:0]  shifted;

    // Insertion point of TDI: top bit of the selected path length.
    always_comb begin
        case (sel)
            SEL_IDCODE: top_idx = TOP_ID;
            SEL_USIG:   top_idx = TOP_USIG;
            SEL_STATUS: top_idx = TOP_STAT;
            default:    top_idx = TOP_BYP;
        endcase
    end

    always_comb begin
        shifted          = dr_q.shift >> 1;
        shifted[top_idx] = tdi;
    end

    always_comb begin
        dr_d = dr_q;
        case (state)
            ST_DR_CAPTURE: begin
                case (sel)
                    SEL_IDCODE: dr_d.shift = DR_W'({ID_VALUE[ID_W-1:1], 1'b1});
                    SEL_USIG:   dr_d.shift = DR_W'(dr_q.usig);
                    SEL_STATUS: dr_d.shift = DR_W'(status_in);
                    default:    dr_d.shift = '0;
                endcase
            end
            ST_DR_SHIFT: begin
                dr_d.shift = shifted;
            end
            ST_DR_UPDATE: begin
                if (usig_wr_en) begin
                    dr_d.usig = dr_q.shift[USIG_W-1:0];
                end
            end
            default: begin
                dr_d = dr_q;
            end
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            dr_q <= '{shift: '0, usig: USIG_INIT};
        end else begin
            dr_q <= dr_d;
        end
    end

    assign dr_lsb = dr_q.shift[0];
    assign usig   = dr_q.usig;

endmodule

// File: rtl/scan_tap_out.sv
module scan_tap_out
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  tap_state_e state,
    input  logic       ir_lsb,
    input  logic       dr_lsb,
    output logic       tdo,
    output logic       tdo_oe
);

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.oe = 1'b0;
        case (state)
            ST_DR_SHIFT: begin
                out_d.tdo = dr_lsb;
                out_d.oe  = 1'b1;
            end
            ST_IR_SHIFT: begin
                out_d.tdo = ir_lsb;
                out_d.oe  = 1'b1;
            end
            default: begin
                out_d.tdo = out_q.tdo;
            end
        endcase
    end

    // Falling-edge stage: the output settles half a clock before the far end samples it.
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            out_q <= '{tdo: 1'b0, oe: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign tdo    = out_q.tdo;
    assign tdo_oe = out_q.oe;

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
    import scan_tap_pkg::*;
#(
    parameter int                ID_W      = 32,
    parameter logic [ID_W-1:0]   ID_VALUE  = 32'h1B3C_5A71,
    parameter int                USIG_W    = 16,
    parameter logic [USIG_W-1:0] USIG_INIT = 16'hA5C3,
    parameter int                STAT_W    = 12
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [STAT_W-1:0] status_in,
    output logic              tdo,
    output logic              tdo_oe
);

    tap_state_e        state;
    logic              ir_lsb;
    logic [IR_W-1:0]   ir_active;
    dr_sel_e           dr_sel;
    logic              usig_wr_en;
    logic              dr_lsb;
    logic [USIG_W-1:0] usig;

    assign dr_sel     = decode_op(ir_active);
    assign usig_wr_en = (ir_active == OP_USIG_WR);

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir #(
        .CAPTURE_OP (OP_IDCODE)
    ) u_ir (
        .tck       (tck),
        .por_n     (por_n),
        .state     (state),
        .tdi       (tdi),
        .ir_lsb    (ir_lsb),
        .ir_active (ir_active)
    );

    scan_tap_dr #(
        .ID_W      (ID_W),
        .ID_VALUE  (ID_VALUE),
        .USIG_W    (USIG_W),
        .USIG_INIT (USIG_INIT),
        .STAT_W    (STAT_W)
    ) u_dr (
        .tck        (tck),
        .por_n      (por_n),
        .state      (state),
        .tdi        (tdi),
        .sel        (dr_sel),
        .usig_wr_en (usig_wr_en),
        .status_in  (status_in),
        .dr_lsb     (dr_lsb),
        .usig       (usig)
    );

    scan_tap_out u_out (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .ir_lsb (ir_lsb),
        .dr_lsb (dr_lsb),
        .tdo    (tdo),
        .tdo_oe (tdo_oe)
    );

endmodule

// File: rtl/scan_tap_port_chk.sv
module scan_tap_port_chk
    import scan_tap_pkg::*;
#(
    parameter int USIG_W = 16
) (
    input logic              tck,
    input logic              por_n,
    input logic              tms,
    input logic              tdo,
    input logic              tdo_oe,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir_active,
    input logic              ir_lsb,
    input logic              dr_lsb,
    input dr_sel_e           dr_sel,
    input logic [USIG_W-1:0] usig
);

    a_r2_reset_sticky: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    a_r1_reset_selects_id: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |=> (ir_active == OP_IDCODE));

    a_r3_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

    a_r3_tdo_held: assert property (@(posedge tck) disable iff (!por_n)
        !(state == ST_DR_SHIFT || state == ST_IR_SHIFT) |-> $stable(tdo));

    a_r4_capture_opcode: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_IR_CAPTURE) |=> (ir_lsb == OP_IDCODE[0]));

    a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_CAPTURE && dr_sel == SEL_BYPASS) |=> !dr_lsb);

    a_r9_usig_write_guard: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(usig) |-> ($past(state) == ST_DR_UPDATE && $past(ir_active) == OP_USIG_WR));

    a_r10_pause_holds: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_PAUSE) |=> $stable(dr_lsb));

endmodule

bind scan_tap_port scan_tap_port_chk #(.USIG_W(USIG_W)) u_chk (
    .tck       (tck),
    .por_n     (por_n),
    .tms       (tms),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe),
    .state     (state),
    .ir_active (ir_active),
    .ir_lsb    (ir_lsb),
    .dr_lsb    (dr_lsb),
    .dr_sel    (dr_sel),
    .usig      (usig)
);

// File: tb/scan_tap_port_bench.sv
module scan_tap_port_bench;

    localparam logic [31:0] ID   = 32'h1B3C_5A71;
    localparam logic [15:0] UINI = 16'hA5C3;

    localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3;
    localparam int M_SHD = 4,  M_E1D = 5,  M_PDR = 6,  M_E2D = 7;
    localparam int M_UDR = 8,  M_SIR = 9,  M_CIR = 10, M_SHI = 11;
    localparam int M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

    logic        tck = 1'b0;
    logic        por_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [11:0] status_in = 12'h000;
    logic        tdo, tdo_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int        m_st;
    bit [5:0]  m_ir_sh, m_ir;
    bit        m_q[$];
    bit [15:0] m_usig;
    bit        m_tdo, m_oe;

    always #5 tck = ~tck;

    scan_tap_port u_scan_tap_port (
        .tck       (tck),
        .por_n     (por_n),
        .tms       (tms),
        .tdi       (tdi),
        .status_in (status_in),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_next(input int s, input bit t);
        case (s)
            M_TLR: return t ? M_TLR : M_RTI;
            M_RTI: return t ? M_SDR : M_RTI;
            M_SDR: return t ? M_SIR : M_CDR;
            M_CDR: return t ? M_E1D : M_SHD;
            M_SHD: return t ? M_E1D : M_SHD;
            M_E1D: return t ? M_UDR : M_PDR;
            M_PDR: return t ? M_E2D : M_PDR;
            M_E2D: return t ? M_UDR : M_SHD;
            M_UDR: return t ? M_SDR : M_RTI;
            M_SIR: return t ? M_TLR : M_CIR;
            M_CIR: return t ? M_E1I : M_SHI;
            M_SHI: return t ? M_E1I : M_SHI;
            M_E1I: return t ? M_UIR : M_PIR;
            M_PIR: return t ? M_E2I : M_PIR;
            M_E2I: return t ? M_UIR : M_SHI;
            default: return t ? M_SDR : M_RTI;
        endcase
    endfunction

    task automatic model_reset();
        m_st = M_TLR; m_ir = 6'h01; m_ir_sh = 6'h00;
        m_q.delete(); m_usig = UINI; m_tdo = 1'b0; m_oe = 1'b0;
    endtask

    task automatic model_rise(input bit t, input bit d);
        case (m_st)
            M_TLR: m_ir = 6'h01;
            M_CIR: m_ir_sh = 6'h01;
            M_SHI: m_ir_sh = {d, m_ir_sh[5:1]};
            M_UIR: m_ir = m_ir_sh;
            M_CDR: begin
                m_q.delete();
                case (m_ir)
                    6'h01: for (int i = 0; i < 32; i++) m_q.push_back(i == 0 ? 1'b1 : ID[i]);
                    6'h02, 6'h03: for (int i = 0; i < 16; i++) m_q.push_back(m_usig[i]);
                    6'h04: for (int i = 0; i < 12; i++) m_q.push_back(status_in[i]);
                    default: m_q.push_back(1'b0);
                endcase
            end
            M_SHD: begin
                void'(m_q.pop_front());
                m_q.push_back(d);
            end
            M_UDR: if (m_ir == 6'h03) for (int i = 0; i < 16; i++) m_usig[i] = m_q[i];
            default: ;
        endcase
        m_st = m_next(m_st, t);
    endtask

    task automatic model_fall();
        if (m_st == M_SHD) begin
            m_tdo = m_q[0]; m_oe = 1'b1;
        end else if (m_st == M_SHI) begin
            m_tdo = m_ir_sh[0]; m_oe = 1'b1;
        end else begin
            m_oe = 1'b0;
        end
    endtask

    // One test clock: drive, rising edge, falling edge, compare against the model.
    task automatic tick(input bit t, input bit d);
        logic pre;
        tms = t; tdi = d; pre = tdo;
        @(posedge tck); #1;
        chk("R3 tdo unchanged at rising edge", {31'd0, tdo}, {31'd0, pre});
        model_rise(t, d);
        @(negedge tck); #1;
        model_fall();
        chk("R3 tdo vs model", {31'd0, tdo}, {31'd0, m_tdo});
        chk("R3 tdo_oe vs model", {31'd0, tdo_oe}, {31'd0, m_oe});
    endtask

    task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 6; i++) begin
            cap[i] = tdo;
            tick(i == 5, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [5:0]  cap;
        logic [31:0] dout;
        model_reset();
        repeat (3) @(negedge tck);
        #1;
        chk("R1 tdo_oe low in reset", {31'd0, tdo_oe}, 32'd0);
        chk("R1 tdo low in reset", {31'd0, tdo}, 32'd0);
        por_n = 1'b1;
        tick(1, 0);
        tick(0, 0);

        // R5 / R1: identification word read blind after reset
        scan_dr(32, 32'h0, dout);
        chk("R5 R1 blind id read", dout, ID);

        // R4 capture pattern, R6 bypass
        scan_ir(6'h3F, cap);
        chk("R4 capture-ir pattern", {26'd0, cap}, 32'h01);
        scan_dr(1, 32'h1, dout);
        chk("R6 bypass captures zero", dout, 32'h0);
        scan_dr(8, 32'hB6, dout);
        chk("R6 bypass one-bit delay", dout, 32'h6C);
        scan_ir(6'h15, cap);
        scan_dr(1, 32'h1, dout);
        chk("R6 unknown opcode is bypass", dout, 32'h0);
        scan_ir(6'h00, cap);
        scan_dr(4, 32'hF, dout);
        chk("R6 opcode zero is bypass", dout, 32'hE);

        // R7 user signature read, write, read back
        scan_ir(6'h02, cap);
        chk("R4 capture-ir pattern again", {26'd0, cap}, 32'h01);
        scan_dr(16, 32'h0, dout);
        chk("R7 R1 usig initial", dout, {16'd0, UINI});
        scan_ir(6'h03, cap);
        scan_dr(16, 32'h5A3C, dout);
        chk("R7 write scan returns old usig", dout, {16'd0, UINI});
        scan_ir(6'h02, cap);
        scan_dr(16, 32'hFFFF, dout);
        chk("R7 usig written", dout, 32'h5A3C);
        // R9 update under read opcode must not write
        scan_dr(16, 32'h0, dout);
        chk("R9 read-opcode update ignored", dout, 32'h5A3C);
        scan_ir(6'h04, cap);
        scan_dr(12, 32'hFFF, dout);
        scan_ir(6'h02, cap);
        scan_dr(16, 32'h0, dout);
        chk("R9 status update ignored", dout, 32'h5A3C);

        // R8 status capture
        status_in = 12'hC35;
        scan_ir(6'h04, cap);
        scan_dr(12, 32'h0, dout);
        chk("R8 status captured", dout, 32'hC35);
        status_in = 12'h0A6;
        scan_dr(12, 32'h0, dout);
        chk("R8 status recaptured", dout, 32'h0A6);

        // R10 pause in the middle of an id scan
        scan_ir(6'h01, cap);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 10; i++) begin
            dout[i] = tdo;
            tick(i == 9, 0);
        end
        tick(0, 0);
        for (int k = 0; k < 3; k++) begin
            tick(0, 1);
            chk("R10 oe low in pause", {31'd0, tdo_oe}, 32'd0);
        end
        tick(1, 0); tick(0, 0);
        for (int i = 10; i < 32; i++) begin
            dout[i] = tdo;
            tick(i == 31, 0);
        end
        tick(1, 0); tick(0, 0);
        chk("R10 resumed scan complete", dout, ID);

        // R2 reset from mid Shift-DR
        scan_ir(6'h3F, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int k = 0; k < 5; k++) tick(1, 0);
        tick(1, 0);
        tick(0, 0);
        scan_dr(32, 32'h0, dout);
        chk("R2 reset from shift-dr reselects id", dout, ID);

        // R2 reset from Pause-IR
        scan_ir(6'h04, cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(1, 1); tick(0, 0);
        for (int k = 0; k < 5; k++) tick(1, 0);
        tick(0, 0);
        scan_dr(32, 32'h0, dout);
        chk("R2 reset from pause-ir reselects id", dout, ID);

        // R11 idle does nothing
        for (int k = 0; k < 8; k++) begin
            tick(0, k[0]);
            chk("R11 oe low in idle", {31'd0, tdo_oe}, 32'd0);
        end
        scan_dr(32, 32'h0, dout);
        chk("R11 id intact after idle", dout, ID);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule